// File: doc/BRIEF.md
# PLCP Receive Error Event Counter

This block counts path-level errors seen by the receive side of a PLCP-style framed cell stream. Once per row it is given the two received framing bytes, the row's path overhead indicator byte and the row number. Once per frame it is given the locally computed BIP-8 value together with the received B1 byte. It also receives a pulse for each out-of-frame event. Two saturating counters, one for framing errors and one for parity errors, are read through a latch strobe. The strobe copies each live count into a holding output and restarts the count from zero.

Each counter has two counting granularities. Framing errors are counted either per mismatching byte or per out-of-frame event. Parity errors are counted either per mismatching bit or as at most one block error per frame. The per-frame parity count is also returned as a remote error indication (REI) value for the transmit side. The three mode controls take effect only at a frame boundary, which is the B1 strobe. This keeps each frame's errors under a single counting mode.

Top module: `plcp_rx_errcnt`

## Requirements
- R1: After reset, both holding outputs and the REI output are 0, both live counts are 0, and the active mode is byte framing, POI checked, bit parity.
- R2: In byte framing mode, each row strobe adds one for each mismatch among A1 against F6h, A2 against 28h, and the POI byte against the value expected for `row_idx`. Rows 0..11 expect 2Ch, 29h, 25h, 20h, 1Ch, 19h, 15h, 10h, 0Dh, 08h, 04h, 01h in that order, so one row adds 0 to 3.
- R3: In byte framing mode with POI disable active, POI byte mismatches add nothing, and only A1 and A2 mismatches count.
- R4: In OOF framing mode, each cycle with `oof_evt` high adds exactly one. Row strobes and the POI disable control have no effect on the framing count.
- R5: In bit parity mode, each B1 strobe adds the number of set bits in `frm_bip` XOR `frm_b1`, which is 0 to 8.
- R6: In block parity mode, each B1 strobe adds 1 if `frm_bip` differs from `frm_b1` in any bit, and 0 otherwise.
- R7: On each B1 strobe, `rei` takes the amount that strobe added to the parity count (0..8), visible the cycle after. Between strobes `rei` holds its value.
- R8: Each live count saturates at 2^CNT_W-1 (FFFFh at the default width) and never wraps.
- R9: A `lat_stb` cycle copies each live count to its holding output and restarts the count from zero. An error arriving in that same cycle goes into the new count.
- R10: The mode inputs are sampled only in a B1 strobe cycle and apply from the following cycle. Errors in the strobe cycle itself, including that frame's B1 result, use the previous mode.
- R11: In byte framing mode, `oof_evt` has no effect on the framing count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_vld | input | 1 | Row overhead strobe |
| row_a1 | input | 8 | Received first framing byte |
| row_a2 | input | 8 | Received second framing byte |
| row_poi | input | 8 | Received path overhead indicator byte |
| row_idx | input | 4 | Row number 0..11 |
| frm_vld | input | 1 | B1 comparison strobe, frame boundary |
| frm_bip | input | 8 | Locally computed BIP-8 |
| frm_b1 | input | 8 | Received B1 byte |
| oof_evt | input | 1 | Out-of-frame event pulse |
| cfg_oof_mode | input | 1 | 1 = count OOF events, 0 = count byte errors |
| cfg_poi_dis | input | 1 | 1 = ignore POI byte errors in byte mode |
| cfg_blk_mode | input | 1 | 1 = block parity counting, 0 = bit counting |
| lat_stb | input | 1 | Latch-and-clear strobe |
| fe_hold | output | CNT_W | Latched framing error count |
| pe_hold | output | CNT_W | Latched parity error count |
| rei | output | 4 | Per-frame REI value |

## Verification
The assertions assume that `row_idx` is always inside 0..11 while `row_vld` is high. The bench only ever drives row numbers from its twelve-entry sweep. The assertions also assume that a single parity increment cannot reach the saturation limit, which the width check at elaboration guarantees. The bench sweeps every row against every combination of bad framing, A2 and POI bytes, both with POI disable on and with it off. It sweeps every mismatch weight 0..8 in both parity modes. It changes the modes only through B1 strobes, except in the one test that checks that a mode change between strobes is held back.

// File: rtl/plcp_errcnt_pkg.sv
package plcp_errcnt_pkg;

   localparam int          BYTE_W   = 8;
   localparam int          ROWS     = 12;
   localparam int          IDX_W    = 4;
   localparam int          REI_W    = $clog2(BYTE_W + 1);
   localparam int          FE_INC_W = 2;
   localparam logic [7:0]  A1_EXP   = 8'hF6;
   localparam logic [7:0]  A2_EXP   = 8'h28;

   typedef struct packed {
      logic oof_mode;
      logic poi_dis;
      logic blk_mode;
   } mode_t;

   // Row 0 carries the highest indicator code, row 11 the lowest.
   function automatic logic [7:0] poi_expected(input logic [IDX_W-1:0] idx);
      logic [7:0] v;
      case (idx)
         4'd0:    v = 8'h2C;
         4'd1:    v = 8'h29;
         4'd2:    v = 8'h25;
         4'd3:    v = 8'h20;
         4'd4:    v = 8'h1C;
         4'd5:    v = 8'h19;
         4'd6:    v = 8'h15;
         4'd7:    v = 8'h10;
         4'd8:    v = 8'h0D;
         4'd9:    v = 8'h08;
         4'd10:   v = 8'h04;
         4'd11:   v = 8'h01;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/plcp_fe_detect.sv
module plcp_fe_detect
   import plcp_errcnt_pkg::*;
(
   input  logic                 oof_mode,
   input  logic                 poi_dis,
   input  logic                 row_vld,
   input  logic [7:0]           row_a1,
   input  logic [7:0]           row_a2,
   input  logic [7:0]           row_poi,
   input  logic [IDX_W-1:0]     row_idx,
   input  logic                 oof_evt,
   output logic [FE_INC_W-1:0]  fe_inc
);

   logic a1_bad, a2_bad, poi_bad;
   logic [FE_INC_W-1:0] byte_sum;

   always_comb begin
      a1_bad   = (row_a1 != A1_EXP);
      a2_bad   = (row_a2 != A2_EXP);
      poi_bad  = !poi_dis && (row_poi != poi_expected(row_idx));
      byte_sum = FE_INC_W'(a1_bad) + FE_INC_W'(a2_bad) + FE_INC_W'(poi_bad);
      if (oof_mode)
         fe_inc = FE_INC_W'(oof_evt);
      else if (row_vld)
         fe_inc = byte_sum;
      else
         fe_inc = '0;
   end

endmodule

// File: rtl/plcp_bip_eval.sv
module plcp_bip_eval
   import plcp_errcnt_pkg::*;
(
   input  logic               blk_mode,
   input  logic [BYTE_W-1:0]  bip,
   input  logic [BYTE_W-1:0]  b1,
   output logic [REI_W-1:0]   pe_raw
);

   logic [BYTE_W-1:0] diff;
   logic [REI_W-1:0]  part [0:BYTE_W];

   assign diff    = bip ^ b1;
   assign part[0] = '0;

   // Adder chain over the mismatch vector.
   for (genvar g = 0; g < BYTE_W; g++) begin : g_pop
      assign part[g+1] = part[g] + REI_W'(diff[g]);
   end

   assign pe_raw = blk_mode ? REI_W'(|diff) : part[BYTE_W];

endmodule

// File: rtl/plcp_sat_cnt.sv
module plcp_sat_cnt #(
   parameter int CNT_W = 16,
   parameter int INC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INC_W-1:0]  inc,
   input  logic              lat,
   output logic [CNT_W-1:0]  hold
);

   localparam logic [CNT_W-1:0] MAX_CNT = '1;

   if (INC_W >= CNT_W) begin : g_bad_width
      $error("plcp_sat_cnt: INC_W must be below CNT_W");
   end

   logic [CNT_W-1:0] cnt, base, nxt;
   logic [CNT_W:0]   sum;

   always_comb begin
      base = lat ? '0 : cnt;
      sum  = {1'b0, base} + (CNT_W+1)'(inc);
      nxt  = sum[CNT_W] ? MAX_CNT : sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         hold <= '0;
      end else begin
         cnt <= nxt;
         if (lat) hold <= cnt;
      end
   end

   a_r8_sat_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == MAX_CNT && !lat) |=> cnt == MAX_CNT);
   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !lat |=> cnt >= $past(cnt));
   a_r9_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
      lat |=> hold == $past(cnt));
   a_r9_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
      lat |=> cnt == CNT_W'($past(inc)));
   a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !lat |=> $stable(hold));

endmodule

// File: rtl/plcp_rx_errcnt.sv
module plcp_rx_errcnt
   import plcp_errcnt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_vld,
   input  logic [7:0]        row_a1,
   input  logic [7:0]        row_a2,
   input  logic [7:0]        row_poi,
   input  logic [3:0]        row_idx,
   input  logic              frm_vld,
   input  logic [7:0]        frm_bip,
   input  logic [7:0]        frm_b1,
   input  logic              oof_evt,
   input  logic              cfg_oof_mode,
   input  logic              cfg_poi_dis,
   input  logic              cfg_blk_mode,
   input  logic              lat_stb,
   output logic [CNT_W-1:0]  fe_hold,
   output logic [CNT_W-1:0]  pe_hold,
   output logic [3:0]        rei
);

   if (CNT_W <= REI_W || CNT_W > 32) begin : g_bad_cnt_w
      $error("plcp_rx_errcnt: CNT_W must be in %0d..32", REI_W + 1);
   end

   mode_t                mode_q;
   logic [FE_INC_W-1:0]  fe_inc;
   logic [REI_W-1:0]     pe_raw, pe_inc;

   // Mode only moves at a frame boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         rei    <= '0;
      end else if (frm_vld) begin
         mode_q <= '{oof_mode: cfg_oof_mode, poi_dis: cfg_poi_dis, blk_mode: cfg_blk_mode};
         rei    <= pe_inc;
      end
   end

   plcp_fe_detect i_fe_detect (
      .oof_mode (mode_q.oof_mode),
      .poi_dis  (mode_q.poi_dis),
      .row_vld  (row_vld),
      .row_a1   (row_a1),
      .row_a2   (row_a2),
      .row_poi  (row_poi),
      .row_idx  (row_idx),
      .oof_evt  (oof_evt),
      .fe_inc   (fe_inc)
   );

   plcp_bip_eval i_bip_eval (
      .blk_mode (mode_q.blk_mode),
      .bip      (frm_bip),
      .b1       (frm_b1),
      .pe_raw   (pe_raw)
   );

   assign pe_inc = frm_vld ? pe_raw : '0;

   plcp_sat_cnt #(.CNT_W(CNT_W), .INC_W(FE_INC_W)) i_fe_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (fe_inc),
      .lat   (lat_stb),
      .hold  (fe_hold)
   );

   plcp_sat_cnt #(.CNT_W(CNT_W), .INC_W(REI_W)) i_pe_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (pe_inc),
      .lat   (lat_stb),
      .hold  (pe_hold)
   );

   a_r2_row_idx_legal: assert property (@(posedge clk) disable iff (!rst_n)
      row_vld |-> row_idx < IDX_W'(ROWS));
   a_r4_oof_single: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q.oof_mode |-> fe_inc <= FE_INC_W'(1));
   a_r11_oof_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q.oof_mode && !row_vld) |-> fe_inc == '0);
   a_r6_block_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && mode_q.blk_mode) |=> rei <= 4'd1);
   a_r7_rei_range: assert property (@(posedge clk) disable iff (!rst_n)
      rei <= 4'(BYTE_W));
   a_r7_rei_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_vld |=> $stable(rei));
   a_r10_mode_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_vld |=> $stable(mode_q));

endmodule

// File: tb/test_plcp_rx_errcnt.sv
`timescale 1ns/1ps
module test_plcp_rx_errcnt;

   localparam int CW  = 8;
   localparam int MAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic row_vld = 0, frm_vld = 0, oof_evt = 0, lat_stb = 0;
   logic cfg_oof_mode = 0, cfg_poi_dis = 0, cfg_blk_mode = 0;
   logic [7:0] row_a1 = 8'hF6, row_a2 = 8'h28, row_poi = 8'h2C, frm_bip = 0, frm_b1 = 0;
   logic [3:0] row_idx = 0;
   logic [CW-1:0] fe_hold, pe_hold;
   logic [3:0] rei;

   int checks = 0, errors = 0;
   bit done = 0;
   int m_fe = 0, m_pe = 0, m_hfe = 0, m_hpe = 0, m_rei = 0;
   bit m_oof = 0, m_pdis = 0, m_blk = 0;
   byte unsigned poi_tab [12] = '{8'h2C, 8'h29, 8'h25, 8'h20, 8'h1C, 8'h19,
                                  8'h15, 8'h10, 8'h0D, 8'h08, 8'h04, 8'h01};

   always #2 clk = ~clk;

   plcp_rx_errcnt #(.CNT_W(CW)) i_plcp_rx_errcnt (
      .clk, .rst_n, .row_vld, .row_a1, .row_a2, .row_poi, .row_idx,
      .frm_vld, .frm_bip, .frm_b1, .oof_evt, .cfg_oof_mode, .cfg_poi_dis,
      .cfg_blk_mode, .lat_stb, .fe_hold, .pe_hold, .rei
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int popc(input logic [7:0] v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += int'(v[i]);
      return n;
   endfunction

   function automatic int sat(input int v);
      return (v > MAX) ? MAX : v;
   endfunction

   // Model the coming clock edge from the driven inputs, then advance one cycle.
   task automatic tick();
      int fi, pi;
      if (m_oof) fi = int'(oof_evt);
      else if (row_vld)
         fi = int'(row_a1 != 8'hF6) + int'(row_a2 != 8'h28)
            + int'(!m_pdis && row_poi != poi_tab[row_idx]);
      else fi = 0;
      if (!frm_vld) pi = 0;
      else pi = m_blk ? int'(frm_bip != frm_b1) : popc(frm_bip ^ frm_b1);
      if (lat_stb) begin
         m_hfe = m_fe; m_hpe = m_pe; m_fe = 0; m_pe = 0;
      end
      m_fe = sat(m_fe + fi);
      m_pe = sat(m_pe + pi);
      if (frm_vld) begin
         m_rei = pi; m_oof = cfg_oof_mode; m_pdis = cfg_poi_dis; m_blk = cfg_blk_mode;
      end
      @(negedge clk);
      row_vld = 0; frm_vld = 0; oof_evt = 0; lat_stb = 0;
      row_a1 = 8'hF6; row_a2 = 8'h28; row_idx = 0; row_poi = 8'h2C;
      frm_bip = 0; frm_b1 = 0;
   endtask

   task automatic frame(input logic [7:0] mask);
      frm_vld = 1; frm_bip = 8'h5A; frm_b1 = 8'h5A ^ mask;
      tick();
   endtask

   task automatic row(input int r, input int pat);
      row_vld = 1; row_idx = 4'(r);
      row_a1  = pat[0] ? 8'hF7 : 8'hF6;
      row_a2  = pat[1] ? 8'h29 : 8'h28;
      row_poi = pat[2] ? (poi_tab[r] ^ 8'h80) : poi_tab[r];
      tick();
   endtask

   task automatic latch();
      lat_stb = 1;
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 fe_hold reset", int'(fe_hold), 0);
      check("R1 pe_hold reset", int'(pe_hold), 0);
      check("R1 rei reset", int'(rei), 0);
      row(0, 4);                      // POI counted by default mode
      latch();
      check("R1 default mode counts POI", int'(fe_hold), 1);

      // R2 / R3: every row against every bad-byte combination
      for (int pd = 0; pd < 2; pd++) begin
         cfg_poi_dis = pd[0];
         frame(8'h00);
         check("R7 rei zero on clean frame", int'(rei), 0);
         for (int r = 0; r < 12; r++)
            for (int pat = 0; pat < 8; pat++) begin
               row(r, pat);
               latch();
               check(pd ? "R3 poi disabled count" : "R2 byte error count",
                     int'(fe_hold), int'(pat[0]) + int'(pat[1]) + (pd ? 0 : int'(pat[2])));
            end
      end
      cfg_poi_dis = 0;

      // R5 / R6 / R7: every mismatch weight in both parity modes
      for (int b = 0; b < 2; b++) begin
         cfg_blk_mode = b[0];
         frame(8'h00);
         for (int k = 0; k <= 8; k++) begin
            frame(8'((9'h1 << k) - 9'h1) << (k % 3 == 0 ? 0 : 0));
            check("R7 rei per frame", int'(rei), b ? int'(k > 0) : k);
            latch();
            check(b ? "R6 block parity count" : "R5 bit parity count",
                  int'(pe_hold), b ? int'(k > 0) : k);
            check("R7 rei held", int'(rei), m_rei);
         end
      end

      // R10: mode changes wait for a frame boundary
      cfg_oof_mode = 1;
      row(3, 7);
      latch();
      check("R10 byte mode kept mid-frame", int'(fe_hold), 3);
      cfg_blk_mode = 0;
      frame(8'hFF);
      check("R10 strobe frame uses old block mode", int'(rei), 1);
      frame(8'hFF);
      check("R10 new bit mode applied", int'(rei), 8);
      latch();

      // R4: OOF counting, rows and POI disable ignored
      for (int i = 0; i < 5; i++) begin
         cfg_poi_dis = i[0];
         oof_evt = 1;
         row(i, 7);
      end
      row(6, 7);
      latch();
      check("R4 oof events only", int'(fe_hold), 5);
      check("R4 model agree", int'(fe_hold), m_hfe);
      cfg_oof_mode = 0; cfg_poi_dis = 0;
      frame(8'h00);

      // R11: oof pulses ignored in byte mode
      for (int i = 0; i < 4; i++) begin
         oof_evt = 1;
         tick();
      end
      latch();
      check("R11 oof ignored in byte mode", int'(fe_hold), 0);

      // R9: latch cycle keeps a coincident event
      row(2, 7);
      row_vld = 1; row_idx = 5; row_a1 = 8'h00; row_a2 = 8'h00; row_poi = poi_tab[5];
      frm_vld = 1; frm_bip = 8'h0F; frm_b1 = 8'h00;
      lat_stb = 1;
      tick();
      check("R9 latched framing count", int'(fe_hold), 3);
      check("R9 latched parity count", int'(pe_hold), 0);
      latch();
      check("R9 coincident framing error kept", int'(fe_hold), 2);
      check("R9 coincident parity error kept", int'(pe_hold), 4);

      // R8: saturation of both counters
      for (int i = 0; i < 40; i++) frame(8'hFF);
      for (int i = 0; i < 90; i++) row(i % 12, 7);
      latch();
      check("R8 parity saturates", int'(pe_hold), MAX);
      check("R8 framing saturates", int'(fe_hold), MAX);
      frame(8'h01);
      latch();
      check("R8 restart after saturation", int'(pe_hold), 1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule